// File: doc/BRIEF.md
# Tiled Surface Layout Parameter Calculator

This block works out the memory layout of a compressed display surface that lives in a low-power tiled region of DRAM. A caller presents the visible width and height of the surface, the DRAM geometry (row size in bytes, bank count, channel count, channel interleave size) and a raw base address, then pulses `start`. A fixed number of cycles later the block returns four encoded geometry fields, the base address rounded up to the tiling alignment, the pitch of a compressed line, and the number of DRAM rows each channel must hold. A `done` pulse marks the result and `invalid_cfg` flags any input that has no encoding.

The alignment unit is the product of row size, bank count and channel count. Two ceiling divisions by this unit are needed: one sizes the region and one aligns the base. Both run side by side in a restoring shift-subtract divider with one quotient bit per cycle. A new request is taken only when the unit is idle. Every result stays on the outputs until the next `done`.

Top module: `surf_layout_calc`

## Requirements
- R1: For the accepted request, let the unit be row_bytes × bank_cnt × chan_cnt. rows_per_chan is then the ceiling of (aligned width × even height × 4) / unit. It is 0 when the unit is 0.
- R2: The aligned width is view_w rounded up to the next multiple of 256. The even height is view_h rounded up to the next even number.
- R3: aligned_base is base_addr rounded up to the next multiple of the unit, using ADDR_W+1 bits so that it cannot wrap. It equals base_addr when the unit is 0 or when base_addr is already a multiple of the unit.
- R4: pitch is the aligned width divided by 8, so its five low bits are always zero.
- R5: bank_code encodes the bank count as 2→0, 4→1, 8→2, 16→3. chan_code encodes the channel count as 1→0, 2→1.
- R6: ilv_code encodes the interleave as 256→0, 512→1. row_code encodes the row size as 1024→0, 2048→1, 4096→2. row_code is never 3.
- R7: A field whose input has no listed encoding keeps its previous value, and invalid_cfg is 1 for that result. invalid_cfg is 0 when all four inputs encode.
- R8: A request is accepted on a clock edge where start is 1 and the unit is idle. All outputs update, with done high for exactly one cycle, 33 edges after the accepting edge.
- R9: start is ignored from the accepting edge up to and including the edge that raises done. A request held high on the following edge is accepted there.
- R10: Reset clears every output to zero. Outputs change only on the edge that raises done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled when idle |
| view_w | input | DIM_W | Visible width in pixels |
| view_h | input | DIM_W | Visible height in lines |
| row_bytes | input | ROW_W | DRAM row size in bytes |
| bank_cnt | input | BANK_W | DRAM bank count |
| chan_cnt | input | CHAN_W | DRAM channel count |
| ilv_bytes | input | ILV_W | Channel interleave size in bytes |
| base_addr | input | ADDR_W | Unaligned surface base address |
| bank_code | output | 2 | Encoded bank count |
| chan_code | output | 2 | Encoded channel count |
| ilv_code | output | 2 | Encoded interleave size |
| row_code | output | 2 | Encoded row size |
| aligned_base | output | ADDR_W+1 | Base rounded up to the alignment unit |
| pitch | output | DIM_W-2 | Compressed line pitch |
| rows_per_chan | output | DIV_W | DRAM rows needed per channel |
| done | output | 1 | One-cycle result strobe |
| invalid_cfg | output | 1 | Some input of the last request had no encoding |

## Verification
The bench targets requests where rounding matters. These include a product that divides exactly, where a design that always adds one would report an extra row, and an odd height of one line, which must count as two. A base of all ones must carry into the extra address bit, and a narrow result would wrap to zero. A zero unit must give zero rows and leave the base untouched rather than return the garbage from a divide by zero. Requests with several unencodable fields must keep the old codes, and a design that wrote zero would show a changed field. A start held high across a whole operation checks that the busy window ends exactly at done: a design that releases one edge early or late takes the second request at the wrong time and shifts every later comparison.

// File: rtl/surf_layout_pkg.sv
package surf_layout_pkg;

  typedef struct packed {
    logic       ok;
    logic [1:0] code;
  } enc_t;

  function automatic enc_t enc_bank(input logic [31:0] v);
    enc_t e;
    e = '0;
    case (v)
      32'd2:   e = '{ok: 1'b1, code: 2'd0};
      32'd4:   e = '{ok: 1'b1, code: 2'd1};
      32'd8:   e = '{ok: 1'b1, code: 2'd2};
      32'd16:  e = '{ok: 1'b1, code: 2'd3};
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic enc_t enc_chan(input logic [31:0] v);
    enc_t e;
    e = '0;
    case (v)
      32'd1:   e = '{ok: 1'b1, code: 2'd0};
      32'd2:   e = '{ok: 1'b1, code: 2'd1};
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic enc_t enc_ilv(input logic [31:0] v);
    enc_t e;
    e = '0;
    case (v)
      32'd256: e = '{ok: 1'b1, code: 2'd0};
      32'd512: e = '{ok: 1'b1, code: 2'd1};
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic enc_t enc_row(input logic [31:0] v);
    enc_t e;
    e = '0;
    case (v)
      32'd1024: e = '{ok: 1'b1, code: 2'd0};
      32'd2048: e = '{ok: 1'b1, code: 2'd1};
      32'd4096: e = '{ok: 1'b1, code: 2'd2};
      default:  e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/surf_field_encoder.sv
module surf_field_encoder
  import surf_layout_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int BANK_W = 6,
  parameter int CHAN_W = 3,
  parameter int ILV_W  = 11
) (
  input  logic [ROW_W-1:0]  row_bytes,
  input  logic [BANK_W-1:0] bank_cnt,
  input  logic [CHAN_W-1:0] chan_cnt,
  input  logic [ILV_W-1:0]  ilv_bytes,
  output enc_t              row_e,
  output enc_t              bank_e,
  output enc_t              chan_e,
  output enc_t              ilv_e
);

  always_comb begin
    row_e  = enc_row(32'(row_bytes));
    bank_e = enc_bank(32'(bank_cnt));
    chan_e = enc_chan(32'(chan_cnt));
    ilv_e  = enc_ilv(32'(ilv_bytes));
  end

endmodule

// File: rtl/surf_seq_divider.sv
module surf_seq_divider #(
  parameter int W     = 32,
  parameter int LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [LANES-1:0][W-1:0]   dividend,
  input  logic [LANES-1:0][W-1:0]   divisor,
  output logic [LANES-1:0][W-1:0]   quot,
  output logic [LANES-1:0][W-1:0]   rem,
  output logic                      fin
);

  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt_q;

  // one shared iteration counter for every lane
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        cnt_q <= CNT_W'(W);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) fin <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [W-1:0] q_l, r_l, d_l, q_n, r_n;
    logic [W:0]   shf;

    // restoring step: shift in next dividend bit, subtract if it fits
    always_comb begin
      shf = {r_l, q_l[W-1]};
      if (shf >= {1'b0, d_l}) begin
        r_n = W'(shf - {1'b0, d_l});
        q_n = {q_l[W-2:0], 1'b1};
      end else begin
        r_n = shf[W-1:0];
        q_n = {q_l[W-2:0], 1'b0};
      end
    end

    always_ff @(posedge clk) begin
      if (load) begin
        q_l <= dividend[g];
        r_l <= '0;
        d_l <= divisor[g];
      end else if (cnt_q != '0) begin
        q_l <= q_n;
        r_l <= r_n;
      end
    end

    assign quot[g] = q_l;
    assign rem[g]  = r_l;
  end

endmodule

// File: rtl/surf_layout_calc.sv
module surf_layout_calc
  import surf_layout_pkg::*;
#(
  parameter int DIM_W     = 14,
  parameter int ROW_W     = 16,
  parameter int BANK_W    = 6,
  parameter int CHAN_W    = 3,
  parameter int ILV_W     = 11,
  parameter int ADDR_W    = 32,
  parameter int CHUNK_PIX = 256,
  localparam int NUM_W    = 2 * DIM_W + 3,
  localparam int DIV_W    = (NUM_W > ADDR_W) ? NUM_W : ADDR_W,
  localparam int PITCH_W  = DIM_W - 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [DIM_W-1:0]    view_w,
  input  logic [DIM_W-1:0]    view_h,
  input  logic [ROW_W-1:0]    row_bytes,
  input  logic [BANK_W-1:0]   bank_cnt,
  input  logic [CHAN_W-1:0]   chan_cnt,
  input  logic [ILV_W-1:0]    ilv_bytes,
  input  logic [ADDR_W-1:0]   base_addr,
  output logic [1:0]          bank_code,
  output logic [1:0]          chan_code,
  output logic [1:0]          ilv_code,
  output logic [1:0]          row_code,
  output logic [ADDR_W:0]     aligned_base,
  output logic [PITCH_W-1:0]  pitch,
  output logic [DIV_W-1:0]    rows_per_chan,
  output logic                done,
  output logic                invalid_cfg
);

  localparam int AW_W   = DIM_W + 1;
  localparam int UNIT_W = ROW_W + BANK_W + CHAN_W;
  localparam int AB_W   = ADDR_W + 1;

  // ---------------- operand preparation ----------------
  logic [AW_W-1:0]   aw_c, eh_c;
  logic [NUM_W-1:0]  num_c;
  logic [UNIT_W-1:0] unit_c;
  logic [PITCH_W-1:0] pitch_c;

  always_comb begin
    aw_c    = (AW_W'(view_w) + AW_W'(CHUNK_PIX - 1)) & ~AW_W'(CHUNK_PIX - 1);
    eh_c    = (AW_W'(view_h) + AW_W'(1)) & ~AW_W'(1);
    num_c   = (NUM_W'(aw_c) * NUM_W'(eh_c)) << 2;
    unit_c  = UNIT_W'(row_bytes) * UNIT_W'(bank_cnt) * UNIT_W'(chan_cnt);
    pitch_c = PITCH_W'(aw_c >> 3);
  end

  enc_t row_e, bank_e, chan_e, ilv_e;

  surf_field_encoder #(
    .ROW_W (ROW_W),
    .BANK_W(BANK_W),
    .CHAN_W(CHAN_W),
    .ILV_W (ILV_W)
  ) enc_i (
    .row_bytes(row_bytes),
    .bank_cnt (bank_cnt),
    .chan_cnt (chan_cnt),
    .ilv_bytes(ilv_bytes),
    .row_e    (row_e),
    .bank_e   (bank_e),
    .chan_e   (chan_e),
    .ilv_e    (ilv_e)
  );

  // ---------------- control ----------------
  logic busy_q;
  logic accept;
  assign accept = start && !busy_q;

  // ---------------- divider: lane 0 sizes region, lane 1 aligns base ----------------
  logic [1:0][DIV_W-1:0] dvd, dvs, quot, rem;
  logic                  fin;

  assign dvd[0] = DIV_W'(num_c);
  assign dvd[1] = DIV_W'(base_addr);
  assign dvs[0] = DIV_W'(unit_c);
  assign dvs[1] = DIV_W'(unit_c);

  surf_seq_divider #(
    .W    (DIV_W),
    .LANES(2)
  ) div_i (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .dividend(dvd),
    .divisor (dvs),
    .quot    (quot),
    .rem     (rem),
    .fin     (fin)
  );

  // ---------------- captured request ----------------
  logic [UNIT_W-1:0]  unit_q;
  logic [ADDR_W-1:0]  base_q;
  logic [PITCH_W-1:0] pitch_q;
  enc_t               row_q, bank_q, chan_q, ilv_q;

  // ---------------- result formation ----------------
  logic [DIV_W-1:0] rows_c;
  logic [AB_W-1:0]  steps_c, aligned_c;

  always_comb begin
    rows_c    = quot[0] + DIV_W'(rem[0] != '0);
    steps_c   = AB_W'(quot[1]) + AB_W'(rem[1] != '0);
    aligned_c = AB_W'(steps_c * AB_W'(unit_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q        <= 1'b0;
      done          <= 1'b0;
      unit_q        <= '0;
      base_q        <= '0;
      pitch_q       <= '0;
      row_q         <= '0;
      bank_q        <= '0;
      chan_q        <= '0;
      ilv_q         <= '0;
      bank_code     <= '0;
      chan_code     <= '0;
      ilv_code      <= '0;
      row_code      <= '0;
      aligned_base  <= '0;
      pitch         <= '0;
      rows_per_chan <= '0;
      invalid_cfg   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        unit_q  <= unit_c;
        base_q  <= base_addr;
        pitch_q <= pitch_c;
        row_q   <= row_e;
        bank_q  <= bank_e;
        chan_q  <= chan_e;
        ilv_q   <= ilv_e;
      end
      if (fin) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
        pitch  <= pitch_q;
        if (unit_q == '0) begin
          rows_per_chan <= '0;
          aligned_base  <= AB_W'(base_q);
        end else begin
          rows_per_chan <= rows_c;
          aligned_base  <= aligned_c;
        end
        if (bank_q.ok) bank_code <= bank_q.code;
        if (chan_q.ok) chan_code <= chan_q.code;
        if (ilv_q.ok)  ilv_code  <= ilv_q.code;
        if (row_q.ok)  row_code  <= row_q.code;
        invalid_cfg <= !(bank_q.ok && chan_q.ok && ilv_q.ok && row_q.ok);
      end
    end
  end

endmodule

// File: rtl/surf_layout_checker.sv
module surf_layout_checker #(
  parameter int DIV_W     = 32,
  parameter int ADDR_W    = 32,
  parameter int PITCH_W   = 12,
  parameter int CHUNK_PIX = 256
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               invalid_cfg,
  input logic [1:0]         row_code,
  input logic [1:0]         bank_code,
  input logic [PITCH_W-1:0] pitch,
  input logic [DIV_W-1:0]   rows_per_chan,
  input logic [ADDR_W:0]    aligned_base
);

  localparam int LAT   = DIV_W + 2;
  localparam int LAT_W = $clog2(LAT + 2);
  localparam int ZB    = $clog2(CHUNK_PIX) - 3;

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst)                 lat_q <= '0;
    else if (start && !busy) lat_q <= LAT_W'(1);
    else if (done)           lat_q <= '0;
    else if (lat_q != '0)    lat_q <= lat_q + 1'b1;
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == LAT_W'(LAT)));

  assert_busy_window_R9: assert property (@(posedge clk) disable iff (rst)
    (lat_q != '0 && !done) |-> busy);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({rows_per_chan, aligned_base, pitch, row_code, bank_code, invalid_cfg}));

  assert_pitch_low_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (pitch[ZB-1:0] == '0));

  assert_row_code_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (row_code != 2'd3));

endmodule

bind surf_layout_calc surf_layout_checker #(
  .DIV_W    (DIV_W),
  .ADDR_W   (ADDR_W),
  .PITCH_W  (PITCH_W),
  .CHUNK_PIX(CHUNK_PIX)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy_q),
  .done         (done),
  .invalid_cfg  (invalid_cfg),
  .row_code     (row_code),
  .bank_code    (bank_code),
  .pitch        (pitch),
  .rows_per_chan(rows_per_chan),
  .aligned_base (aligned_base)
);

// File: tb/surf_layout_calc_tb.sv
module surf_layout_calc_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [13:0] view_w = '0, view_h = '0;
  logic [15:0] row_bytes = '0;
  logic [5:0]  bank_cnt = '0;
  logic [2:0]  chan_cnt = '0;
  logic [10:0] ilv_bytes = '0;
  logic [31:0] base_addr = '0;

  logic [1:0]  bank_code, chan_code, ilv_code, row_code;
  logic [32:0] aligned_base;
  logic [11:0] pitch;
  logic [31:0] rows_per_chan;
  logic        done, invalid_cfg;

  surf_layout_calc dut_i (
    .clk(clk), .rst(rst), .start(start),
    .view_w(view_w), .view_h(view_h), .row_bytes(row_bytes),
    .bank_cnt(bank_cnt), .chan_cnt(chan_cnt), .ilv_bytes(ilv_bytes),
    .base_addr(base_addr),
    .bank_code(bank_code), .chan_code(chan_code), .ilv_code(ilv_code),
    .row_code(row_code), .aligned_base(aligned_base), .pitch(pitch),
    .rows_per_chan(rows_per_chan), .done(done), .invalid_cfg(invalid_cfg)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  // ---------------- behavioural reference ----------------
  longint e_rows, e_base, e_pitch, e_bank, e_chan, e_ilv, e_row, e_inv, e_done;
  longint p_rows, p_base, p_pitch;
  int     p_bank, p_chan, p_ilv, p_row;
  int     wait_n = 0;
  bit     model_live = 0;

  function automatic int code_of(int kind, longint v);
    case (kind)
      0: case (v) 2: return 0; 4: return 1; 8: return 2; 16: return 3; default: return -1; endcase
      1: case (v) 1: return 0; 2: return 1; default: return -1; endcase
      2: case (v) 256: return 0; 512: return 1; default: return -1; endcase
      default: case (v) 1024: return 0; 2048: return 1; 4096: return 2; default: return -1; endcase
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_rows = 0; e_base = 0; e_pitch = 0; e_bank = 0; e_chan = 0;
      e_ilv = 0; e_row = 0; e_inv = 0; e_done = 0; wait_n = 0;
    end else begin
      e_done = 0;
      if (wait_n > 0) begin
        wait_n--;
        if (wait_n == 0) begin
          e_done = 1; e_rows = p_rows; e_base = p_base; e_pitch = p_pitch;
          if (p_bank >= 0) e_bank = p_bank;
          if (p_chan >= 0) e_chan = p_chan;
          if (p_ilv  >= 0) e_ilv  = p_ilv;
          if (p_row  >= 0) e_row  = p_row;
          e_inv = (p_bank < 0 || p_chan < 0 || p_ilv < 0 || p_row < 0) ? 1 : 0;
        end
      end else if (start) begin
        longint unit, aw, eh, num, b;
        unit = longint'(row_bytes) * longint'(bank_cnt) * longint'(chan_cnt);
        aw = ((longint'(view_w) + 255) / 256) * 256;
        eh = ((longint'(view_h) + 1) / 2) * 2;
        num = aw * eh * 4;
        b = longint'(base_addr);
        p_rows  = (unit == 0) ? 0 : (num + unit - 1) / unit;
        p_base  = (unit == 0) ? b : ((b + unit - 1) / unit) * unit;
        p_pitch = aw / 8;
        p_bank = code_of(0, longint'(bank_cnt));
        p_chan = code_of(1, longint'(chan_cnt));
        p_ilv  = code_of(2, longint'(ilv_bytes));
        p_row  = code_of(3, longint'(row_bytes));
        wait_n = 33;
      end
    end
    model_live = 1;
  end

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (model_live) begin
      chk("R8 R9 done", longint'(done), e_done);
      chk("R1 R2 rows_per_chan", longint'(rows_per_chan), e_rows);
      chk("R3 aligned_base", longint'(aligned_base), e_base);
      chk("R4 pitch", longint'(pitch), e_pitch);
      chk("R5 R7 bank_code", longint'(bank_code), e_bank);
      chk("R5 R7 chan_code", longint'(chan_code), e_chan);
      chk("R6 R7 ilv_code", longint'(ilv_code), e_ilv);
      chk("R6 R7 row_code", longint'(row_code), e_row);
      chk("R7 invalid_cfg", longint'(invalid_cfg), e_inv);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL R8 watchdog actual=%0d expected<20000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic set_in(int w, int h, int rb, int bk, int ch, int il, longint b);
    view_w = 14'(w); view_h = 14'(h); row_bytes = 16'(rb);
    bank_cnt = 6'(bk); chan_cnt = 3'(ch); ilv_bytes = 11'(il); base_addr = 32'(b);
  endtask

  task automatic op(int w, int h, int rb, int bk, int ch, int il, longint b);
    @(negedge clk);
    set_in(w, h, rb, bk, ch, il, b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (36) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values at the ports
    chk("R10 reset rows", longint'(rows_per_chan), 0);
    chk("R10 reset base", longint'(aligned_base), 0);
    chk("R10 reset done", longint'(done), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    op(1920, 1080, 2048, 8, 2, 256, 64'h0001_2345);    // R1 R3 typical
    op(2560, 1600, 4096, 16, 1, 512, 64'h0010_0000);   // R3 already aligned
    op(256, 1, 1024, 2, 1, 256, 0);                    // R2 exact division, odd height
    op(1, 3, 1024, 2, 1, 512, 64'hFFFF_FFFF);          // R3 carry into extra bit
    op(100, 100, 0, 8, 2, 256, 64'h1234);              // R1 R3 R7 zero unit
    op(640, 480, 2048, 3, 2, 384, 64'h5000);           // R7 bad banks and interleave
    op(16383, 16383, 4096, 16, 2, 512, 64'hABCDE);     // R2 R4 largest view
    op(800, 600, 2048, 4, 4, 256, 64'h7777);           // R7 bad channel count
    op(1000, 7, 3000, 8, 1, 256, 77);                  // R1 R7 odd unit, bad row

    // R9: start held high through a whole operation and beyond
    @(negedge clk);
    set_in(1280, 720, 2048, 8, 2, 512, 64'h3_0001);
    start = 1'b1;
    @(negedge clk);
    set_in(333, 555, 1024, 16, 1, 256, 64'h9_9999);
    repeat (40) @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);

    summary();
    $finish;
  end

endmodule